// File: doc/BRIEF.md
# Memory Window Bridge with Address Translation

This block is a register-mapped slave that gives a small local agent a window into a much larger system memory. Software loads a local address register and then reads or writes a single data register. Each data access becomes one memory beat: a read fetches a 64-bit word from memory, and a write sends the data register contents out. After each beat the local address steps forward by one word, so a series of data-register accesses walks through memory without any further address writes.

The system address is formed at the start of every access, so each access uses the current configuration. It is built from the local address, a base address input and a mask input. The high bits come from the base. The middle bits are picked one at a time from the local address or from the base, as the mask says. The low offset comes straight from the local address.

A control/status register reports the access in progress and a busy field. While that field shows busy, data accesses are held off. Six read-buffer status registers and two write-buffer status registers are marked whenever a beat completes.

The controller is a four-state machine:
- **ST_IDLE** accepts requests.
- **ST_LOAD** latches the translated address.
- **ST_ISSUE** presents the memory request until it is accepted.
- **ST_ACK** answers the register port for one cycle.

The transitions are:
- *accept-data*: ST_IDLE to ST_LOAD, a data access with the gate bit clear.
- *accept-reg*: ST_IDLE to ST_ACK, any other register access.
- *gated*: ST_IDLE to ST_ACK, a data access with the gate bit set.
- *latched*: ST_LOAD to ST_ISSUE.
- *handshake*: ST_ISSUE to ST_ACK, when `mem_ready` is seen.
- *reply*: ST_ACK to ST_IDLE.

Top module: `mem_window_bridge`

## Requirements
Bit positions are given MSB-0 within 64-bit registers: bit n is bit [63-n] counted from the least significant end. Register index map on `reg_idx`:

| Index | Register |
|---|---|
| 0 | local address |
| 1 | control/status |
| 2 | data |
| 3..8 | read buffers 0..5 |
| 9..10 | write buffers 0..1 |
| 11..15 | unused (read as zero, writes ignored) |

Control/status fields:

| MSB-0 bit | LSB-0 bit | Field |
|---|---|---|
| 2 | [61] | reset request |
| 7 | [56] | in-progress |
| 8..11 | [55:52] | busy field |
| 11 | [52] | access gate |

- R1: A data-register access while control bit 11 ([52]) is set makes no memory request. It is acknowledged in the cycle after the request with `reg_rdata` zero, and it leaves the local address and the control register unchanged.
- R2: Each completed data access adds 8 to bits [26:0] of the local address register, wrapping within that 27-bit field. Bits [63:27] are unchanged.
- R3: System address bits 8..22 ([55:41]) equal the same bits of `cfg_bar`. Bits 0..7 ([63:56]) are zero.
- R4: For system address bits 23..43 ([40:20]), each bit is taken from the local address where the same bit of `cfg_mask` is 1, and from `cfg_bar` where it is 0.
- R5: System address bits 44..63 ([19:0]) equal the local address bits [19:0].
- R6: The address of each access is translated from the local address, base and mask current at that access. This includes the value after the previous increment. `mem_addr` and `mem_we` hold steady while `mem_valid` waits for `mem_ready`.
- R7: A completed read sets bits 33..39 ([30:24]) of all six read-buffer registers to 7'b0000001. It keeps their other bits and leaves the write buffers unchanged.
- R8: A completed write sends the written word on `mem_wdata` and sets bits 35..39 ([28:24]) of both write-buffer registers to 5'b00001. It keeps their other bits and leaves the read buffers unchanged.
- R9: A completed access clears in-progress bit 7 ([56]) and the busy field, bits 8..11 ([55:52]). An access runs to completion whenever bit 11 is clear, even if other busy bits are set.
- R10: A control-register write with reset-request bit 2 ([61]) set clears in-progress bit 7. Bit 2 always reads back 0.
- R11: While a memory beat is outstanding, in-progress is set and the busy field is nonzero. For a data read, `reg_ack` rises exactly one cycle after the `mem_valid`/`mem_ready` handshake and returns `mem_rdata`. A data write acknowledges with zero.
- R12: Accesses to registers other than data are acknowledged one cycle after the request with a one-cycle `reg_ack`. Register writes read back as written, except for R10, and the reset value of every register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request, held until `reg_ack` |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 64 | Register write data |
| reg_ack | output | 1 | One-cycle access acknowledge |
| reg_rdata | output | 64 | Read data, valid with `reg_ack` |
| cfg_bar | input | 64 | Base address configuration |
| cfg_mask | input | 64 | Per-bit select mask for the middle address field |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 64 | Translated system address |
| mem_wdata | output | 64 | Memory write data |
| mem_ready | input | 1 | Memory accepts the beat; read data valid |
| mem_rdata | input | 64 | Memory read data |

## Verification
A wrong address register or translation shows up as a wrong `mem_addr` on the very next data access. A bad increment is exposed on the access that follows it, and the wrap case is driven directly. A stuck in-progress or busy bit either blocks the next data access, so no memory beat appears and the read returns zero, or it is read back through the control register one access later. Buffer-flag corruption is visible on the first buffer read after a completed beat. Pre-loading the buffers with all ones shows whether neighbouring bits were disturbed.

// File: rtl/mwb_pkg.sv
`timescale 1ns/1ps
package mwb_pkg;

    localparam int WORD_W = 64;
    localparam int IDX_W  = 4;

    // register index map
    localparam int IDX_ADDR  = 0;
    localparam int IDX_CTRL  = 1;
    localparam int IDX_DATA  = 2;
    localparam int IDX_RBUF0 = 3;

    // LSB-0 positions of fields specified MSB-0
    localparam int CTL_RST_REQ = WORD_W - 1 - 2;
    localparam int CTL_INPROG  = WORD_W - 1 - 7;
    localparam int CTL_BUSY_HI = WORD_W - 1 - 8;
    localparam int CTL_BUSY_LO = WORD_W - 1 - 11;
    localparam int BUF_FLAG    = WORD_W - 1 - 39;
    localparam int RBUF_FW     = 7;
    localparam int WBUF_FW     = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ISSUE,
        ST_ACK
    } mwb_state_e;

    typedef struct packed {
        logic              we;
        logic [WORD_W-1:0] addr;
    } mwb_cmd_t;

endpackage

// File: rtl/mwb_xlate.sv
`timescale 1ns/1ps
module mwb_xlate #(
    parameter int W      = 64,
    parameter int OFS_W  = 20,
    parameter int SEL_HI = 40,
    parameter int BAR_HI = 55
) (
    input  logic [W-1:0] local_addr,
    input  logic [W-1:0] bar,
    input  logic [W-1:0] mask,
    output logic [W-1:0] sys_addr
);

    // bits the translation never looks at
    logic unused_bits;
    assign unused_bits = ^{local_addr[W-1:SEL_HI+1], bar[OFS_W-1:0], bar[W-1:BAR_HI+1],
                           mask[OFS_W-1:0], mask[W-1:SEL_HI+1]};

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < OFS_W) begin : g_ofs
            assign sys_addr[i] = local_addr[i];
        end else if (i <= SEL_HI) begin : g_sel
            assign sys_addr[i] = mask[i] ? local_addr[i] : bar[i];
        end else if (i <= BAR_HI) begin : g_bar
            assign sys_addr[i] = bar[i];
        end else begin : g_zero
            assign sys_addr[i] = 1'b0;
        end
    end

endmodule

// File: rtl/mwb_incr.sv
`timescale 1ns/1ps
module mwb_incr #(
    parameter int W       = 64,
    parameter int FIELD_W = 27,
    parameter int STEP    = 8
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);

    localparam logic [FIELD_W-1:0] STEP_V = FIELD_W'(STEP);

    assign nxt = {cur[W-1:FIELD_W], cur[FIELD_W-1:0] + STEP_V};

endmodule

// File: rtl/mwb_fsm.sv
`timescale 1ns/1ps
module mwb_fsm
    import mwb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       is_data,
    input  logic       gate,
    input  logic       mem_ready,
    output mwb_state_e state_o,
    output logic       start_acc,
    output logic       blocked_acc,
    output logic       reg_op,
    output logic       load_addr,
    output logic       xfer_done,
    output logic       mem_valid,
    output logic       ack
);

    mwb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (is_data && !gate) state_d = ST_LOAD;
                    else                  state_d = ST_ACK;
                end
            end
            ST_LOAD:  state_d = ST_ISSUE;
            ST_ISSUE: if (mem_ready) state_d = ST_ACK;
            ST_ACK:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        start_acc   = 1'b0;
        blocked_acc = 1'b0;
        reg_op      = 1'b0;
        load_addr   = 1'b0;
        xfer_done   = 1'b0;
        mem_valid   = 1'b0;
        ack         = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start_acc   = req && is_data && !gate;
                blocked_acc = req && is_data && gate;
                reg_op      = req && !is_data;
            end
            ST_LOAD:  load_addr = 1'b1;
            ST_ISSUE: begin
                mem_valid = 1'b1;
                xfer_done = mem_ready;
            end
            ST_ACK:   ack = 1'b1;
            default: ;
        endcase
    end

    assign state_o = state_q;

    // R12: the acknowledge is a single-cycle pulse
    assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R11: the request stays up until the memory accepts it
    assert_valid_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> mem_valid);

endmodule

// File: rtl/mem_window_bridge.sv
`timescale 1ns/1ps
module mem_window_bridge
    import mwb_pkg::*;
#(
    parameter int N_RBUF   = 6,
    parameter int N_WBUF   = 2,
    parameter int INC_W    = 27,
    parameter int INC_STEP = 8,
    parameter int OFS_W    = 20,
    parameter int SEL_HI   = 40,
    parameter int BAR_HI   = 55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic              reg_ack,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [WORD_W-1:0] cfg_bar,
    input  logic [WORD_W-1:0] cfg_mask,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata
);

    localparam int IDX_WBUF0 = IDX_RBUF0 + N_RBUF;
    localparam int BUSY_W    = CTL_BUSY_HI - CTL_BUSY_LO + 1;

    logic [WORD_W-1:0] lar_q, lar_inc, sys_addr;
    logic [WORD_W-1:0] ctl_q, ctl_wr;
    logic [WORD_W-1:0] data_q, rdata_q, rd_mux;
    logic [WORD_W-1:0] rbuf_q [N_RBUF];
    logic [WORD_W-1:0] wbuf_q [N_WBUF];
    mwb_cmd_t          cmd_q;
    mwb_state_e        state;

    logic is_data, gate;
    logic start_acc, blocked_acc, reg_op, load_addr, xfer_done;
    logic wr_op;

    assign is_data = (reg_idx == IDX_W'(IDX_DATA));
    assign gate    = ctl_q[CTL_BUSY_LO];
    assign wr_op   = reg_op && reg_we;

    mwb_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (reg_req),
        .is_data     (is_data),
        .gate        (gate),
        .mem_ready   (mem_ready),
        .state_o     (state),
        .start_acc   (start_acc),
        .blocked_acc (blocked_acc),
        .reg_op      (reg_op),
        .load_addr   (load_addr),
        .xfer_done   (xfer_done),
        .mem_valid   (mem_valid),
        .ack         (reg_ack)
    );

    mwb_xlate #(
        .W      (WORD_W),
        .OFS_W  (OFS_W),
        .SEL_HI (SEL_HI),
        .BAR_HI (BAR_HI)
    ) u_xlate (
        .local_addr (lar_q),
        .bar        (cfg_bar),
        .mask       (cfg_mask),
        .sys_addr   (sys_addr)
    );

    mwb_incr #(
        .W       (WORD_W),
        .FIELD_W (INC_W),
        .STEP    (INC_STEP)
    ) u_incr (
        .cur (lar_q),
        .nxt (lar_inc)
    );

    // ---------------- local address register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n)                                  lar_q <= '0;
        else if (wr_op && reg_idx == IDX_W'(IDX_ADDR)) lar_q <= reg_wdata;
        else if (xfer_done)                          lar_q <= lar_inc;
    end

    // ---------------- control / status register ----------------
    always_comb begin
        ctl_wr = reg_wdata;
        ctl_wr[CTL_RST_REQ] = 1'b0;
        if (reg_wdata[CTL_RST_REQ]) ctl_wr[CTL_INPROG] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (start_acc) begin
            ctl_q[CTL_INPROG] <= 1'b1;
            ctl_q[CTL_BUSY_HI:CTL_BUSY_LO] <= '1;
        end else if (xfer_done) begin
            ctl_q[CTL_INPROG] <= 1'b0;
            ctl_q[CTL_BUSY_HI:CTL_BUSY_LO] <= '0;
        end else if (wr_op && reg_idx == IDX_W'(IDX_CTRL)) begin
            ctl_q <= ctl_wr;
        end
    end

    // ---------------- data register and command ----------------
    always_ff @(posedge clk) begin
        if (!rst_n)                      data_q <= '0;
        else if (start_acc && reg_we)    data_q <= reg_wdata;
        else if (xfer_done && !cmd_q.we) data_q <= mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            if (start_acc) cmd_q.we   <= reg_we;
            if (load_addr) cmd_q.addr <= sys_addr;
        end
    end

    // ---------------- buffer status registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_RBUF; i++) rbuf_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_RBUF; i++) begin
                if (wr_op && reg_idx == IDX_W'(IDX_RBUF0 + i))
                    rbuf_q[i] <= reg_wdata;
                else if (xfer_done && !cmd_q.we)
                    rbuf_q[i][BUF_FLAG +: RBUF_FW] <= RBUF_FW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_WBUF; i++) wbuf_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_WBUF; i++) begin
                if (wr_op && reg_idx == IDX_W'(IDX_WBUF0 + i))
                    wbuf_q[i] <= reg_wdata;
                else if (xfer_done && cmd_q.we)
                    wbuf_q[i][BUF_FLAG +: WBUF_FW] <= WBUF_FW'(1);
            end
        end
    end

    // ---------------- register read path ----------------
    always_comb begin
        rd_mux = '0;
        if (reg_idx == IDX_W'(IDX_ADDR)) rd_mux = lar_q;
        if (reg_idx == IDX_W'(IDX_CTRL)) rd_mux = ctl_q;
        for (int i = 0; i < N_RBUF; i++)
            if (reg_idx == IDX_W'(IDX_RBUF0 + i)) rd_mux = rbuf_q[i];
        for (int i = 0; i < N_WBUF; i++)
            if (reg_idx == IDX_W'(IDX_WBUF0 + i)) rd_mux = wbuf_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           rdata_q <= '0;
        else if (reg_op)      rdata_q <= reg_we ? '0 : rd_mux;
        else if (blocked_acc) rdata_q <= '0;
        else if (xfer_done)   rdata_q <= cmd_q.we ? '0 : mem_rdata;
    end

    assign reg_rdata = rdata_q;
    assign mem_we    = cmd_q.we;
    assign mem_addr  = cmd_q.addr;
    assign mem_wdata = data_q;

    // ---------------- assertions ----------------
    assert_gate_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
        blocked_acc |=> reg_ack && !mem_valid && $stable(lar_q) && $stable(ctl_q));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=>
            lar_q[INC_W-1:0] == $past(lar_q[INC_W-1:0]) + INC_W'(INC_STEP)
            && lar_q[WORD_W-1:INC_W] == $past(lar_q[WORD_W-1:INC_W]));

    assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    assert_rbuf_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !mem_we) |=> rbuf_q[0][BUF_FLAG +: RBUF_FW] == RBUF_FW'(1));

    assert_wbuf_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_we) |=> wbuf_q[0][BUF_FLAG +: WBUF_FW] == WBUF_FW'(1));

    assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=>
            !ctl_q[CTL_INPROG] && ctl_q[CTL_BUSY_HI:CTL_BUSY_LO] == BUSY_W'(0));

    assert_rst_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op && reg_idx == IDX_W'(IDX_CTRL) && reg_wdata[CTL_RST_REQ]) |=>
            !ctl_q[CTL_INPROG] && !ctl_q[CTL_RST_REQ]);

    assert_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ctl_q[CTL_INPROG] && ctl_q[CTL_BUSY_HI:CTL_BUSY_LO] != BUSY_W'(0));

    assert_reg_reply_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && reg_req && !is_data) |=> reg_ack);

endmodule

// File: tb/sim_mem_window_bridge.sv
`timescale 1ns/1ps
module sim_mem_window_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [63:0] reg_wdata = '0;
    logic        reg_ack;
    logic [63:0] reg_rdata;
    logic [63:0] cfg_bar = '0, cfg_mask = '0;
    logic        mem_valid, mem_we;
    logic [63:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [63:0] mem_rdata = '0;

    always #10 clk = ~clk;   // 50 MHz

    mem_window_bridge u0 (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .cfg_bar(cfg_bar), .cfg_mask(cfg_mask), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    int n_chk = 0, n_bad = 0;

    // reference model state
    logic [63:0] m_lar = '0, m_ctl = '0;
    logic [63:0] m_rb [6];
    logic [63:0] m_wb [2];

    // results of the last port transaction
    logic [63:0] a_rdata, a_addr, a_wdata;
    logic        a_we, a_mem_seen, a_unstable;
    int          a_gap;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] f_xlate(input logic [63:0] l, input logic [63:0] b, input logic [63:0] m);
        logic [63:0] r = '0;
        r[55:41] = b[55:41];
        r[40:20] = (l[40:20] & m[40:20]) | (b[40:20] & ~m[40:20]);
        r[19:0]  = l[19:0];
        return r;
    endfunction

    function automatic logic [63:0] f_inc(input logic [63:0] l);
        return {l[63:27], l[26:0] + 27'd8};
    endfunction

    function automatic logic [63:0] m_read(input int idx);
        if (idx == 0) return m_lar;
        if (idx == 1) return m_ctl;
        if (idx >= 3 && idx <= 8) return m_rb[idx-3];
        if (idx == 9 || idx == 10) return m_wb[idx-9];
        return 64'h0;
    endfunction

    task automatic bus(input logic we, input int idx, input logic [63:0] wd,
                       input int lat, input logic [63:0] rv);
        int  wait_n = lat;
        int  guard = 0;
        int  ready_at = -1;
        bit  done = 0;
        a_mem_seen = 0; a_unstable = 0; a_gap = -1;
        @(negedge clk);
        reg_req = 1'b1; reg_we = we; reg_idx = 4'(idx); reg_wdata = wd;
        while (!done) begin
            @(negedge clk);
            guard++;
            if (reg_ack) begin
                a_rdata = reg_rdata;
                if (ready_at >= 0) a_gap = guard - ready_at;
                reg_req = 1'b0; mem_ready = 1'b0; done = 1;
            end else if (mem_valid) begin
                if (!a_mem_seen) begin
                    a_mem_seen = 1; a_addr = mem_addr; a_we = mem_we; a_wdata = mem_wdata;
                end else if (mem_addr != a_addr || mem_we != a_we || mem_wdata != a_wdata) begin
                    a_unstable = 1;
                end
                if (!mem_ready) begin
                    if (wait_n == 0) begin
                        mem_ready = 1'b1; mem_rdata = rv; ready_at = guard;
                    end else wait_n--;
                end
            end
            if (guard > 60 && !done) begin
                chk(0, "R11 access never acknowledged", 64'(guard), 64'd0);
                reg_req = 1'b0; mem_ready = 1'b0; done = 1;
            end
        end
    endtask

    task automatic reg_write(input int idx, input logic [63:0] v);
        bus(1'b1, idx, v, 0, 64'h0);
        if (idx == 0) m_lar = v;
        else if (idx == 1) begin
            m_ctl = v; m_ctl[61] = 1'b0;
            if (v[61]) m_ctl[56] = 1'b0;
        end else if (idx >= 3 && idx <= 8) m_rb[idx-3] = v;
        else if (idx == 9 || idx == 10) m_wb[idx-9] = v;
    endtask

    task automatic reg_check(input int idx, input string tag);
        bus(1'b0, idx, 64'h0, 0, 64'h0);
        chk(a_rdata == m_read(idx), tag, a_rdata, m_read(idx));
    endtask

    task automatic data_acc(input logic we, input logic [63:0] wd, input int lat, input logic [63:0] rv);
        logic [63:0] exp_addr = f_xlate(m_lar, cfg_bar, cfg_mask);
        bit gated = m_ctl[52];
        bus(we, 2, wd, lat, rv);
        if (gated) begin
            chk(!a_mem_seen, "R1 gated access made a memory request", 64'(a_mem_seen), 64'd0);
            chk(a_rdata == 64'h0, "R1 gated access data", a_rdata, 64'h0);
        end else begin
            chk(a_mem_seen, "R11 memory request issued", 64'(a_mem_seen), 64'd1);
            chk(a_addr == exp_addr, "R3 R4 R5 R6 system address", a_addr, exp_addr);
            chk(!a_unstable, "R6 request held while waiting", 64'(a_unstable), 64'd0);
            chk(a_we == we, "R11 request direction", 64'(a_we), 64'(we));
            chk(a_gap == 1, "R11 ack one cycle after handshake", 64'(a_gap), 64'd1);
            if (we) begin
                chk(a_wdata == wd, "R8 write data", a_wdata, wd);
                chk(a_rdata == 64'h0, "R11 write ack data", a_rdata, 64'h0);
                for (int i = 0; i < 2; i++) m_wb[i][28:24] = 5'b00001;
            end else begin
                chk(a_rdata == rv, "R11 read data", a_rdata, rv);
                for (int i = 0; i < 6; i++) m_rb[i][30:24] = 7'b0000001;
            end
            m_ctl[56] = 1'b0; m_ctl[55:52] = 4'h0;
            m_lar = f_inc(m_lar);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h1DEA5EED);
        for (int i = 0; i < 6; i++) m_rb[i] = '0;
        for (int i = 0; i < 2; i++) m_wb[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        reg_check(0, "R12 reset address");
        reg_check(1, "R12 reset control");
        reg_check(5, "R12 reset read buffer");
        reg_check(10, "R12 reset write buffer");

        // write/readback
        reg_write(0, 64'h0000_0123_4567_89A8);
        reg_check(0, "R12 address readback");
        reg_write(7, 64'hDEAD_BEEF_0000_1111);
        reg_check(7, "R12 buffer readback");
        reg_write(12, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_check(12, "R12 unused index reads zero");

        // translation: mask clear -> middle from base (R3 R4 R5)
        cfg_bar = 64'hFFFF_FFFF_FFFF_FFFF; cfg_mask = 64'h0;
        data_acc(1'b0, 64'h0, 0, 64'h1111_2222_3333_4444);
        // mask set -> middle from local address
        cfg_bar = 64'hAAAA_AAAA_AAAA_AAAA; cfg_mask = 64'hFFFF_FFFF_FFFF_FFFF;
        data_acc(1'b0, 64'h0, 2, 64'h5555_6666_7777_8888);
        cfg_mask = 64'h0000_0155_5550_0000;
        data_acc(1'b1, 64'hCAFE_F00D_1234_5678, 3, 64'h0);
        reg_check(0, "R2 address after three beats");

        // R2 wrap within the 27-bit field; R6 next access uses the wrapped value
        reg_write(0, 64'hABCD_0000_07FF_FFF8);
        data_acc(1'b0, 64'h0, 1, 64'h0F0F_0F0F_0F0F_0F0F);
        reg_check(0, "R2 wrap keeps upper bits");
        chk(m_lar == 64'hABCD_0000_0000_0000, "R2 wrapped value", m_lar, 64'hABCD_0000_0000_0000);
        data_acc(1'b0, 64'h0, 0, 64'h1);

        // R7: read marks read buffers, neighbours and write buffers kept
        reg_write(5, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_write(9, 64'h0);
        data_acc(1'b0, 64'h0, 0, 64'h2);
        reg_check(5, "R7 read buffer field");
        chk(m_rb[2] == 64'hFFFF_FFFF_81FF_FFFF, "R7 model value", m_rb[2], 64'hFFFF_FFFF_81FF_FFFF);
        reg_check(9, "R7 write buffer untouched");

        // R8: write marks write buffers, read buffers kept
        reg_write(10, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_write(3, 64'h0);
        data_acc(1'b1, 64'h7777_0000_7777_0000, 2, 64'h0);
        reg_check(10, "R8 write buffer field");
        chk(m_wb[1] == 64'hFFFF_FFFF_E1FF_FFFF, "R8 model value", m_wb[1], 64'hFFFF_FFFF_E1FF_FFFF);
        reg_check(3, "R8 read buffer untouched");

        // R9: busy bits other than the gate bit do not block; completion clears
        reg_write(1, 64'h01E0_0000_0000_0000);
        data_acc(1'b0, 64'h0, 1, 64'h3);
        reg_check(1, "R9 status cleared after access");

        // R1: gate bit blocks access
        reg_write(1, 64'h0010_0000_0000_0000);
        data_acc(1'b0, 64'h0, 0, 64'h9999);
        reg_check(0, "R1 address unchanged when gated");
        reg_check(1, "R1 status unchanged when gated");

        // R10: reset request clears in-progress and reads back zero
        reg_write(1, 64'h0100_0000_0000_0000);
        reg_check(1, "R10 in-progress held without request");
        reg_write(1, 64'h2100_0000_0000_0000);
        reg_check(1, "R10 reset request clears in-progress");

        // constrained random mix
        for (int it = 0; it < 300; it++) begin
            int op = $urandom_range(0, 9);
            if (op <= 4) begin
                data_acc(1'($urandom_range(0, 1)), {$urandom(), $urandom()},
                         $urandom_range(0, 3), {$urandom(), $urandom()});
            end else if (op == 5) begin
                reg_write(0, {$urandom(), $urandom()});
            end else if (op == 6) begin
                logic [63:0] v = {$urandom(), $urandom()};
                if ($urandom_range(0, 3) != 0) v[52] = 1'b0;
                reg_write(1, v);
            end else if (op == 7) begin
                reg_write($urandom_range(3, 10), {$urandom(), $urandom()});
            end else if (op == 8) begin
                int idx = $urandom_range(0, 15);
                if (idx == 2) idx = 1;
                reg_check(idx, "R12 random register readback");
            end else begin
                @(negedge clk);
                cfg_bar = {$urandom(), $urandom()};
                cfg_mask = {$urandom(), $urandom()};
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule